// File: doc/BRIEF.md
# Cellular Automaton Keystream Cipher

This block encrypts or decrypts one byte per step. It XORs each data byte with a keystream word taken from an 8-cell array that evolves under elementary cellular automaton Rule 30. A seed loaded through the key port sets the starting pattern. Each advance strobe moves the automaton one generation forward and combines the new generation with the byte on the data input.

The state lives in two registers. A current-state register holds the present generation, and a next-state register holds the generation just computed. The next-state register also drives the keystream output. A single advance performs both halves of the ping-pong update in one clock: the next-state register captures the successor of the current state, and the current-state register captures that same successor.

Decryption uses the same circuit. Load the seed that was used to encrypt, then present the ciphertext bytes in the order they were produced. Each byte then meets the keystream word that enciphered it, and the output is the plaintext.

Top module: `ca_stream_cipher`

## Requirements
- R1: While reset is high, and on the cycle after it, the keystream output, the data output and the valid flag are all zero.
- R2: A key load copies the seed into the current-state register. In the following cycle the keystream output is zero and the valid flag is low.
- R3: Each new cell i equals L XOR (C OR R). C is cell i, L is cell i+1 and R is cell i-1 of the previous generation. The missing neighbour beyond bit 7 and beyond bit 0 reads as 0. Example: seed 00011110 gives 00110001.
- R4: One cycle after an advance (with no key load), the keystream output equals the Rule 30 successor of the current state, and the current state takes that same value. Repeated advances therefore produce successive generations.
- R5: One cycle after an advance, the data output equals that new keystream word XOR the data input sampled at the advance, and the valid flag is high. Example: keystream 00110001 with data 11010010 gives 11100011.
- R6: In a cycle with neither an advance nor a key load, the state and the keystream output hold. The valid flag is low in the next cycle.
- R7: When a key load and an advance arrive in the same cycle, the key load wins. No step is taken, and no valid result is produced.
- R8: After the same seed is reloaded, feeding the ciphertext bytes in their original order returns the original plaintext bytes.
- R9: An all-zero current state stays all-zero under advances, so the keystream stays zero until the next key load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Load the seed into the current state; clears the keystream word |
| key_in | input | 8 | Seed pattern |
| advance | input | 1 | Step the automaton one generation and combine with data_in |
| data_in | input | 8 | Plaintext or ciphertext byte, sampled with advance |
| keystream | output | 8 | Contents of the next-state register |
| data_out | output | 8 | Keystream XOR data byte |
| data_valid | output | 1 | High for one cycle after each accepted advance |

## Verification
Every result is registered once. The keystream word, the data output and the valid flag all update one clock after the advance or key load that caused them, and a reset takes effect at the first edge. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples one nanosecond later, so each check reads the value due from that single edge. Multi-step sequences repeat this per step and compare against a reference generation computed in the bench from the sum-of-products form of the rule.

// File: rtl/ca_cipher_pkg.sv
package ca_cipher_pkg;

    localparam int CA_W = 8;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } ca_cmd_e;

    // Key load outranks advance.
    function automatic ca_cmd_e decode_cmd(input logic load, input logic adv);
        if (load)
            return CMD_LOAD;
        else if (adv)
            return CMD_STEP;
        else
            return CMD_HOLD;
    endfunction

    function automatic logic rule30_cell(input logic l, input logic c, input logic r);
        return l ^ (c | r);
    endfunction

endpackage

// File: rtl/ca_rule30_next.sv
module ca_rule30_next #(
    parameter int WIDTH = ca_cipher_pkg::CA_W
) (
    input  logic [WIDTH-1:0] cells,
    output logic [WIDTH-1:0] succ
);
    import ca_cipher_pkg::*;

    // Zero-padded view: bit 0 and bit WIDTH+1 are the constant boundaries.
    localparam int PW = WIDTH + 2;
    logic [PW-1:0] padded;

    assign padded = {1'b0, cells, 1'b0};

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            assign succ[i] = rule30_cell(padded[i+2], padded[i+1], padded[i]);
        end
    endgenerate

endmodule

// File: rtl/ca_state_regs.sv
module ca_state_regs #(
    parameter int WIDTH = ca_cipher_pkg::CA_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  ca_cipher_pkg::ca_cmd_e cmd,
    input  logic [WIDTH-1:0]       seed,
    input  logic [WIDTH-1:0]       succ,
    output logic [WIDTH-1:0]       cur_q,
    output logic [WIDTH-1:0]       nxt_q
);
    import ca_cipher_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            nxt_q <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    cur_q <= seed;
                    nxt_q <= '0;
                end
                CMD_STEP: begin
                    nxt_q <= succ;
                    cur_q <= succ;
                end
                default: ;
            endcase
        end
    end

    p_load_seed_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (cur_q == $past(seed) && nxt_q == '0));

    p_pingpong_match_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> (cur_q == nxt_q));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD) |=> ($stable(cur_q) && $stable(nxt_q)));

    p_zero_sticks_r9: assert property (@(posedge clk) disable iff (rst)
        (cur_q == '0 && cmd != CMD_LOAD) |=> (cur_q == '0));

endmodule

// File: rtl/ca_xor_stage.sv
module ca_xor_stage #(
    parameter int WIDTH = ca_cipher_pkg::CA_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  ca_cipher_pkg::ca_cmd_e cmd,
    input  logic [WIDTH-1:0]       succ,
    input  logic [WIDTH-1:0]       din,
    output logic [WIDTH-1:0]       dout,
    output logic                   valid
);
    import ca_cipher_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= (cmd == CMD_STEP);
            if (cmd == CMD_STEP)
                dout <= succ ^ din;
            else if (cmd == CMD_LOAD)
                dout <= '0;
        end
    end

    p_valid_follows_step_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> valid);

    p_valid_low_otherwise_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_STEP) |=> !valid);

endmodule

// File: rtl/ca_stream_cipher.sv
module ca_stream_cipher #(
    parameter int WIDTH = ca_cipher_pkg::CA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_load,
    input  logic [WIDTH-1:0] key_in,
    input  logic             advance,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] keystream,
    output logic [WIDTH-1:0] data_out,
    output logic             data_valid
);
    import ca_cipher_pkg::*;

    ca_cmd_e          cmd;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] nxt_q;
    logic [WIDTH-1:0] succ;

    assign cmd = decode_cmd(key_load, advance);

    ca_rule30_next #(.WIDTH(WIDTH)) u_rule (
        .cells (cur_q),
        .succ  (succ)
    );

    ca_state_regs #(.WIDTH(WIDTH)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .seed  (key_in),
        .succ  (succ),
        .cur_q (cur_q),
        .nxt_q (nxt_q)
    );

    ca_xor_stage #(.WIDTH(WIDTH)) u_xor (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .succ  (succ),
        .din   (data_in),
        .dout  (data_out),
        .valid (data_valid)
    );

    assign keystream = nxt_q;

    p_out_matches_key_r5: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (data_out == (keystream ^ $past(data_in))));

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (keystream == '0 && data_out == '0 && !data_valid));

endmodule

// File: tb/ca_stream_cipher_test.sv
`timescale 1ns/1ps
module ca_stream_cipher_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       key_load;
    logic [7:0] key_in;
    logic       advance;
    logic [7:0] data_in;
    logic [7:0] keystream;
    logic [7:0] data_out;
    logic       data_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    ca_stream_cipher uut (
        .clk(clk), .rst(rst), .key_load(key_load), .key_in(key_in),
        .advance(advance), .data_in(data_in), .keystream(keystream),
        .data_out(data_out), .data_valid(data_valid)
    );

    // Reference successor, sum-of-products form, zero boundaries.
    function automatic logic [7:0] ref_next(input logic [7:0] s);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            logic l, c, rr;
            l  = (i == 7) ? 1'b0 : s[i+1];
            c  = s[i];
            rr = (i == 0) ? 1'b0 : s[i-1];
            r[i] = (~l & c) | (~l & rr) | (l & ~c & ~rr);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample 1 ns later.
    task automatic cycle(input logic ld, input logic [7:0] k, input logic adv, input logic [7:0] d);
        @(negedge clk);
        key_load = ld; key_in = k; advance = adv; data_in = d;
        @(posedge clk);
        #1;
        key_load = 1'b0; advance = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; key_load = 1'b0; advance = 1'b0; key_in = '0; data_in = '0;
        @(posedge clk); #1;
        check("R1 keystream", {1'b0, keystream}, 9'd0);
        check("R1 data_out/valid", {data_valid, data_out}, 9'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_known_vector;
        cycle(1'b1, 8'b00011110, 1'b0, 8'h00);
        check("R2 keystream cleared after load", {data_valid, keystream}, 9'd0);
        cycle(1'b0, 8'h00, 1'b1, 8'b11010010);
        check("R3 known successor", {1'b0, keystream}, {1'b0, 8'b00110001});
        check("R5 known ciphertext", {data_valid, data_out}, {1'b1, 8'b11100011});
    endtask

    task automatic t_sequence(input logic [7:0] seed);
        logic [7:0] st;
        st = seed;
        cycle(1'b1, seed, 1'b0, 8'h00);
        for (int k = 0; k < 10; k++) begin
            logic [7:0] d;
            d  = 8'(k * 37 + 5);
            st = ref_next(st);
            cycle(1'b0, 8'h00, 1'b1, d);
            check("R4 successive generation", {1'b0, keystream}, {1'b0, st});
            check("R5 output combine", {data_valid, data_out}, {1'b1, st ^ d});
        end
    endtask

    task automatic t_idle;
        logic [7:0] ks, nx;
        cycle(1'b1, 8'b10000001, 1'b0, 8'h00);
        cycle(1'b0, 8'h00, 1'b1, 8'hFF);
        ks = keystream;
        check("R3 edge cells", {1'b0, ks}, {1'b0, ref_next(8'b10000001)});
        cycle(1'b0, 8'h00, 1'b0, 8'h5A);
        cycle(1'b0, 8'h00, 1'b0, 8'hA5);
        check("R6 idle holds keystream, valid low", {data_valid, keystream}, {1'b0, ks});
        nx = ref_next(ks);
        cycle(1'b0, 8'h00, 1'b1, 8'h00);
        check("R6 state held across idle", {1'b0, keystream}, {1'b0, nx});
    endtask

    task automatic t_priority;
        cycle(1'b1, 8'b01100100, 1'b0, 8'h00);
        cycle(1'b0, 8'h00, 1'b1, 8'h00);
        cycle(1'b1, 8'b00011110, 1'b1, 8'hFF);
        check("R7 load wins over advance", {data_valid, keystream}, 9'd0);
        cycle(1'b0, 8'h00, 1'b1, 8'h00);
        check("R7 new seed used, no step taken", {1'b0, keystream}, {1'b0, 8'b00110001});
    endtask

    task automatic t_roundtrip;
        logic [7:0] pt [6];
        logic [7:0] ct [6];
        for (int k = 0; k < 6; k++) pt[k] = 8'(8'h41 + k * 11);
        cycle(1'b1, 8'b10110010, 1'b0, 8'h00);
        for (int k = 0; k < 6; k++) begin
            cycle(1'b0, 8'h00, 1'b1, pt[k]);
            ct[k] = data_out;
        end
        cycle(1'b1, 8'b10110010, 1'b0, 8'h00);
        for (int k = 0; k < 6; k++) begin
            cycle(1'b0, 8'h00, 1'b1, ct[k]);
            check("R8 decrypt recovers plaintext", {data_valid, data_out}, {1'b1, pt[k]});
        end
    endtask

    task automatic t_zero;
        cycle(1'b1, 8'h00, 1'b0, 8'h00);
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 8'h00, 1'b1, 8'h3C);
            check("R9 zero state sticks", {data_valid, keystream}, {1'b1, 8'h00});
        end
        check("R9 data passes unchanged", {1'b0, data_out}, {1'b0, 8'h3C});
    endtask

    initial begin
        t_reset();
        t_known_vector();
        t_sequence(8'b00011110);
        t_sequence(8'b11100101);
        t_idle();
        t_priority();
        t_roundtrip();
        t_zero();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule